// File: doc/BRIEF.md
# Memory-backed fixed delay line

This block delays a stream of fixed-width samples by a constant number of cycles. It holds the samples in a small two-port register-array memory instead of a long chain of flip-flops. The data stays where it was written. Two address counters move through the memory: a write counter that marks where the incoming sample goes, and a read counter that marks which older sample leaves. Only the counters change from cycle to cycle, which keeps switching activity and flop count low for long delays.

The delay equals the memory depth, which must be a power of two; both counters wrap modulo the depth. An enable input gates the whole block. While it is low nothing is written, both counters hold and the output holds. Delay is therefore counted in enabled cycles. The memory contents are not reset, so the output has no defined value until one full pass of samples has been written after reset.

Top module: `ram_delay_line`

## Requirements
- R1: While reset (active-low, synchronous) is asserted, and after it is released until the first enabled cycle, `dout_o` reads 0.
- R2: Once the memory has been filled, the value on `dout_o` during enabled cycle c+DEPTH equals the value on `din_i` during enabled cycle c. Cycles are counted from 0 after reset and only cycles with `en_i` high are counted. This covers the output register.
- R3: Reset places the read address at entry 0 and the write address at entry DEPTH-1. As a result, the first sample taken after reset appears on `dout_o` right after the DEPTH-th enabled clock edge.
- R4: Both addresses advance by one on every enabled cycle and wrap from DEPTH-1 to 0. The delay stays exact over any number of passes through the memory.
- R5: In a cycle with `en_i` low, no sample is stored, both addresses hold and `dout_o` keeps its value. The `din_i` value of such a cycle never appears on the output.
- R6: In every enabled cycle the write address differs from the read address: the write address is always the read address minus one, modulo DEPTH. The sample read is therefore never the one written in that same cycle.
- R7: Asserting reset in the middle of a run restarts the block. Afterwards it behaves exactly as after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Advance enable; low freezes the block |
| din_i | input | WIDTH | Sample entering the delay line |
| dout_o | output | WIDTH | Sample leaving the delay line, DEPTH enabled cycles later |

## Verification
The hardest case to reach from the ports is the exact latency across many counter wraps while enable keeps switching. A pointer off by one, or a write that slips through a frozen cycle, shows up only as a sample arriving one position early or late. The stimulus mixes random samples with random enable gaps over many passes of the memory. Directed stretches cover long uninterrupted runs, long frozen bursts, and a reset in mid-stream after the memory is full. Each sample on the output is compared against a reference history indexed by enabled-cycle count.

// File: rtl/dly_pkg.sv
// Package dly_pkg
// Shared defaults for the memory-backed delay line.
// Assumes: depth is a power of two, at least 2.
package dly_pkg;
    parameter int unsigned DLY_DEPTH_DEFAULT = 16;
    parameter int unsigned DLY_WIDTH_DEFAULT = 8;
endpackage

// File: rtl/dly_ptr_counter.sv
// Module dly_ptr_counter
// Free-running address counter with a parameterised reset value.
// It advances by one when enabled and wraps naturally at 2**AW.
// Assumes: synchronous active-low reset; RESET_VAL fits in AW bits.
module dly_ptr_counter #(
    parameter int unsigned AW        = 4,
    parameter logic [AW-1:0] RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    output logic [AW-1:0] cnt_o
);
    // Advance the address on every enabled cycle, load reset value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= RESET_VAL;
        else if (en_i)
            cnt_o <= cnt_o + 1'b1;
    end

    // R3
    rst_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cnt_o == RESET_VAL));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R5
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_o));
endmodule

// File: rtl/dly_dual_port_ram.sv
// Module dly_dual_port_ram
// Register-array memory with one write port and one registered read port.
// The storage is not reset; only the read register clears on reset.
// Assumes: the caller never reads and writes the same entry in one cycle.
module dly_dual_port_ram #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             re_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store the incoming word at the write address.
    always_ff @(posedge clk) begin
        if (rst_n && we_i)
            mem[waddr_i] <= wdata_i;
    end

    // Register the word at the read address; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (re_i)
            rdata_o <= mem[raddr_i];
    end

    // R6
    collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && re_i) |-> (waddr_i != raddr_i));

    // R1
    rdata_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rdata_o == '0));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/ram_delay_line.sv
// Module ram_delay_line
// Fixed delay of DEPTH enabled cycles built from a two-port memory
// and two address counters. The read counter starts at entry 0 and the
// write counter at entry DEPTH-1, so the two addresses stay exactly one
// apart and a sample is read back one full pass after it was written.
// Assumes: DEPTH is a power of two and at least 2; output undefined
// until DEPTH samples have been written after reset.
module ram_delay_line
    import dly_pkg::*;
#(
    parameter int unsigned DEPTH = DLY_DEPTH_DEFAULT,
    parameter int unsigned WIDTH = DLY_WIDTH_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW-1:0] RD_START = '0;
    localparam logic [AW-1:0] WR_START = AW'(DEPTH - 1);

    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;

    // Read address counter, starts at the first entry.
    dly_ptr_counter #(.AW(AW), .RESET_VAL(RD_START)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .cnt_o (rd_ptr)
    );

    // Write address counter, starts at the last entry.
    dly_ptr_counter #(.AW(AW), .RESET_VAL(WR_START)) u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .cnt_o (wr_ptr)
    );

    // Sample storage with a registered read port.
    dly_dual_port_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (en_i),
        .waddr_i (wr_ptr),
        .wdata_i (din_i),
        .re_i    (en_i),
        .raddr_i (rd_ptr),
        .rdata_o (dout_o)
    );

    // R6
    ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (AW'(wr_ptr + 1'b1) == rd_ptr));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(dout_o));
endmodule

// File: tb/tb_ram_delay_line.sv
module tb_ram_delay_line;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned WIDTH = 8;
    localparam int CLK_PERIOD = 10;

    logic             clk;
    logic             rst_n;
    logic             en_i;
    logic [WIDTH-1:0] din_i;
    logic [WIDTH-1:0] dout_o;

    int nchk;
    int nfail;
    int n_en;
    bit rereset;
    bit done;
    logic [WIDTH-1:0] last_out;
    logic [WIDTH-1:0] hist [0:8191];

    ram_delay_line #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .din_i  (din_i),
        .dout_o (dout_o)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: dout_o=%0h expected %0h (enabled cycle %0d)", tag, act, exp, n_en);
        end
    endtask

    // Expected output after an enabled edge, from the reference history.
    function automatic logic [WIDTH-1:0] expected_out(int n);
        return hist[n - DEPTH];
    endfunction

    function automatic string tag_for(int n);
        if (n == DEPTH) return rereset ? "R7" : "R3";
        if (n <= 2*DEPTH) return "R2,R6";
        return "R4";
    endfunction

    // One clock: drive at the falling edge, update model at the rising edge, check at the next falling edge.
    task automatic step(bit e, logic [WIDTH-1:0] d);
        en_i  = e;
        din_i = d;
        @(posedge clk);
        if (e) begin
            hist[n_en] = d;
            n_en++;
        end
        @(negedge clk);
        if (e) begin
            if (n_en >= DEPTH)
                check(tag_for(n_en), dout_o, expected_out(n_en));
        end else begin
            check("R5", dout_o, last_out);
        end
        last_out = dout_o;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            en_i  = 1'b1;
            din_i = WIDTH'($urandom);
            @(posedge clk);
            @(negedge clk);
            check("R1", dout_o, '0);
        end
        rst_n = 1'b1;
        n_en  = 0;
        en_i  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1: output still clear after release, before any enabled cycle
        check("R1", dout_o, '0);
        last_out = dout_o;
    endtask

    initial begin
        int unsigned seed;
        nchk = 0; nfail = 0; n_en = 0; rereset = 1'b0; done = 1'b0;
        rst_n = 1'b0; en_i = 1'b0; din_i = '0; last_out = '0;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        do_reset();

        // R3: first sample, contiguous enable, distinctive pattern
        for (int i = 0; i < 3*DEPTH; i++)
            step(1'b1, WIDTH'(8'hA0 + i));

        // R5: long frozen burst with changing input
        for (int i = 0; i < 20; i++)
            step(1'b0, WIDTH'($urandom));
        for (int i = 0; i < DEPTH + 3; i++)
            step(1'b1, WIDTH'($urandom));

        // R4, R5: random enable and data over many wraps
        for (int i = 0; i < 1500; i++)
            step(($urandom % 4) != 0, WIDTH'($urandom));

        // R7: reset mid-stream with a full memory, then restart
        rereset = 1'b1;
        do_reset();
        for (int i = 0; i < 2*DEPTH; i++)
            step(1'b1, WIDTH'(8'h50 + i));
        for (int i = 0; i < 600; i++)
            step(($urandom % 3) != 0, WIDTH'($urandom));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule